// File: doc/BRIEF.md
# Stack Push/Pop and Call/Return Sequencer

This block carries out the four stack operations of a 32-bit processor (push, pop, call and return) against a stack that lives in an external memory. It owns the stack pointer and the program counter. The stack grows toward lower addresses, and the stack pointer always points at the word currently on top. A push moves the pointer down by one 4-byte slot and then stores the operand there. A pop reads the top word, hands it to a destination write port and then moves the pointer up by one slot. A call stores the address of the following instruction (current PC plus the instruction length) exactly as a push would, and then jumps to the target. A return pops a word into the program counter.

The surrounding pipeline presents one operation at a time through `op_valid` and `op_code`, together with an operand, a call target and the length of the current instruction. A three-state machine sequences the work. In ST_IDLE it accepts a legal request and moves to ST_MEM (transition ACCEPT). In ST_MEM it holds a single memory request until `mem_ready` is seen, then moves to ST_DONE (transition COMMIT) while updating the stack pointer and program counter on that same edge. ST_DONE lasts exactly one cycle, pulses `op_done` and returns to ST_IDLE (transition RETIRE). Push and pop advance the program counter by the instruction length. Memory addresses are byte addresses, always a multiple of 4 when the stack pointer is aligned. A memory with word indexing uses `mem_addr[31:2]`.

Top module: `stack_seq`

## Requirements
- R1: While `rst` is high on a clock edge, `sp_out` loads `sp_init`, `pc_out` loads `pc_init`, and `mem_req`, `op_done` and `dst_we` go low.
- R2: Push (`op_code` 3'd1) issues one write of `src_data` to address SP-4. When `op_done` is high, `sp_out` is SP-4 and `pc_out` is PC+`instr_len`.
- R3: Pop (`op_code` 3'd2) issues one read at address SP. When `op_done` is high, `dst_we` is high with `dst_data` equal to the word read, `sp_out` is SP+4 and `pc_out` is PC+`instr_len`.
- R4: Call (`op_code` 3'd4 is return; 3'd3 is call) writes PC+`instr_len` to address SP-4. When `op_done` is high, `sp_out` is SP-4 and `pc_out` is `call_tgt`.
- R5: Return (`op_code` 3'd4) reads the word at SP. When `op_done` is high, `pc_out` equals that word and `sp_out` is SP+4.
- R6: Once raised, `mem_req` stays high with `mem_addr`, `mem_we` and `mem_wdata` unchanged until a cycle with `mem_ready` high. Any number of wait cycles is tolerated. `mem_req` falls in the cycle after that handshake.
- R7: `op_done` is high for exactly one cycle, in the cycle after the `mem_ready` handshake. `dst_we` is high only in that cycle and only for a pop.
- R8: `op_valid` has no effect while an operation is in progress. Codes 3'd0 and 3'd5 to 3'd7 are ignored: no memory request is made and SP and PC keep their values.
- R9: A push followed by a pop returns the pushed word and restores SP. A call followed by a return restores both SP and the return PC.
- R10: Stack pointer and program counter arithmetic wraps modulo 2^32. For example, a push with SP = 0 writes at 0xFFFFFFFC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sp_init | input | 32 | Stack pointer value loaded by reset |
| pc_init | input | 32 | Program counter value loaded by reset |
| op_valid | input | 1 | Operation request, sampled only when idle |
| op_code | input | 3 | 1 push, 2 pop, 3 call, 4 return, others ignored |
| src_data | input | 32 | Operand for push |
| call_tgt | input | 32 | Jump target for call |
| instr_len | input | 4 | Byte length of the current instruction |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | 1 for write, 0 for read |
| mem_addr | output | 32 | Byte address of the stack slot |
| mem_wdata | output | 32 | Write data |
| mem_ready | input | 1 | Memory accepts or completes the request this cycle |
| mem_rdata | input | 32 | Read data, valid with `mem_ready` |
| dst_we | output | 1 | Destination write strobe for pop |
| dst_data | output | 32 | Popped word |
| sp_out | output | 32 | Current stack pointer |
| pc_out | output | 32 | Current program counter |
| op_done | output | 1 | One-cycle completion pulse |

## Verification
The assertions check the following on every cycle:
- a held request keeps its address and direction until `mem_ready`;
- a write always targets one slot below the current stack pointer, and a read always targets the current stack pointer;
- after a write handshake the pointer equals the written address, and after a read handshake it is 4 above the read address;
- `op_done` never lasts two cycles, and `dst_we` appears only with it.

Only the bench scenarios can show the rest: that the operand, return address and popped data have the right values, that the program counter follows the length, target or popped word, and that requests during a busy operation or with unused codes leave no trace. The bench sweeps the memory wait count and the instruction length.

// File: rtl/stk_pkg.sv
package stk_pkg;
    typedef enum logic [2:0] {
        OP_NOP  = 3'd0,
        OP_PUSH = 3'd1,
        OP_POP  = 3'd2,
        OP_CALL = 3'd3,
        OP_RET  = 3'd4
    } stk_op_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_MEM  = 2'd1,
        ST_DONE = 2'd2
    } stk_state_e;

    function automatic logic op_is_legal(input logic [2:0] code);
        return (code == OP_PUSH) || (code == OP_POP) ||
               (code == OP_CALL) || (code == OP_RET);
    endfunction

    function automatic logic op_writes(input stk_op_e op);
        return (op == OP_PUSH) || (op == OP_CALL);
    endfunction
endpackage

// File: rtl/stk_ctrl.sv
module stk_ctrl
    import stk_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic mem_ready,
    output logic accept,
    output logic commit,
    output logic mem_req,
    output logic op_done
);
    stk_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start)     state_d = ST_MEM;   // ACCEPT
            ST_MEM:  if (mem_ready) state_d = ST_DONE;  // COMMIT
            ST_DONE:                state_d = ST_IDLE;  // RETIRE
            default:                state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        accept  = 1'b0;
        commit  = 1'b0;
        mem_req = 1'b0;
        op_done = 1'b0;
        unique case (state_q)
            ST_IDLE: accept = start;
            ST_MEM: begin
                mem_req = 1'b1;
                commit  = mem_ready;
            end
            ST_DONE: op_done = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/stk_path.sv
module stk_path
    import stk_pkg::*;
#(
    parameter int XLEN       = 32,
    parameter int LEN_W      = 4,
    parameter int SLOT_BYTES = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             accept,
    input  logic             commit,
    input  logic [2:0]       op_code,
    input  logic [XLEN-1:0]  src_data,
    input  logic [XLEN-1:0]  call_tgt,
    input  logic [LEN_W-1:0] instr_len,
    input  logic [XLEN-1:0]  sp_cur,
    input  logic [XLEN-1:0]  pc_cur,
    input  logic [XLEN-1:0]  mem_rdata,
    output stk_op_e          op_q,
    output logic [XLEN-1:0]  addr_q,
    output logic [XLEN-1:0]  wdata_q,
    output logic             we_q,
    output logic [XLEN-1:0]  tgt_q,
    output logic [XLEN-1:0]  seq_pc_q,
    output logic [XLEN-1:0]  rd_q
);
    localparam logic [XLEN-1:0] SLOT = XLEN'(SLOT_BYTES);

    stk_op_e         op_in;
    logic [XLEN-1:0] seq_pc;

    assign op_in  = stk_op_e'(op_code);
    assign seq_pc = pc_cur + XLEN'(instr_len);

    always_ff @(posedge clk) begin
        if (rst) begin
            op_q     <= OP_NOP;
            addr_q   <= '0;
            wdata_q  <= '0;
            we_q     <= 1'b0;
            tgt_q    <= '0;
            seq_pc_q <= '0;
        end else if (accept) begin
            op_q     <= op_in;
            we_q     <= op_writes(op_in);
            addr_q   <= op_writes(op_in) ? sp_cur - SLOT : sp_cur;
            wdata_q  <= (op_in == OP_CALL) ? seq_pc : src_data;
            tgt_q    <= call_tgt;
            seq_pc_q <= seq_pc;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)         rd_q <= '0;
        else if (commit) rd_q <= mem_rdata;
    end
endmodule

// File: rtl/stk_arch.sv
module stk_arch
    import stk_pkg::*;
#(
    parameter int XLEN       = 32,
    parameter int SLOT_BYTES = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [XLEN-1:0] sp_init,
    input  logic [XLEN-1:0] pc_init,
    input  logic            commit,
    input  stk_op_e         op_q,
    input  logic [XLEN-1:0] addr_q,
    input  logic [XLEN-1:0] tgt_q,
    input  logic [XLEN-1:0] seq_pc_q,
    input  logic [XLEN-1:0] mem_rdata,
    output logic [XLEN-1:0] sp_q,
    output logic [XLEN-1:0] pc_q
);
    localparam logic [XLEN-1:0] SLOT = XLEN'(SLOT_BYTES);

    logic [XLEN-1:0] sp_d, pc_d;

    always_comb begin
        sp_d = sp_q;
        pc_d = pc_q;
        if (commit) begin
            unique case (op_q)
                OP_PUSH: begin sp_d = addr_q;        pc_d = seq_pc_q;  end
                OP_CALL: begin sp_d = addr_q;        pc_d = tgt_q;     end
                OP_POP:  begin sp_d = addr_q + SLOT; pc_d = seq_pc_q;  end
                OP_RET:  begin sp_d = addr_q + SLOT; pc_d = mem_rdata; end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sp_q <= sp_init;
            pc_q <= pc_init;
        end else begin
            sp_q <= sp_d;
            pc_q <= pc_d;
        end
    end
endmodule

// File: rtl/stack_seq.sv
module stack_seq
    import stk_pkg::*;
#(
    parameter int XLEN       = 32,
    parameter int LEN_W      = 4,
    parameter int SLOT_BYTES = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [XLEN-1:0]  sp_init,
    input  logic [XLEN-1:0]  pc_init,
    input  logic             op_valid,
    input  logic [2:0]       op_code,
    input  logic [XLEN-1:0]  src_data,
    input  logic [XLEN-1:0]  call_tgt,
    input  logic [LEN_W-1:0] instr_len,
    output logic             mem_req,
    output logic             mem_we,
    output logic [XLEN-1:0]  mem_addr,
    output logic [XLEN-1:0]  mem_wdata,
    input  logic             mem_ready,
    input  logic [XLEN-1:0]  mem_rdata,
    output logic             dst_we,
    output logic [XLEN-1:0]  dst_data,
    output logic [XLEN-1:0]  sp_out,
    output logic [XLEN-1:0]  pc_out,
    output logic             op_done
);
    logic            start, accept, commit;
    stk_op_e         op_q;
    logic [XLEN-1:0] addr_q, wdata_q, tgt_q, seq_pc_q, rd_q;
    logic            we_q;

    assign start = op_valid && op_is_legal(op_code);

    stk_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .mem_ready (mem_ready),
        .accept    (accept),
        .commit    (commit),
        .mem_req   (mem_req),
        .op_done   (op_done)
    );

    stk_path #(.XLEN(XLEN), .LEN_W(LEN_W), .SLOT_BYTES(SLOT_BYTES)) u_path (
        .clk       (clk),
        .rst       (rst),
        .accept    (accept),
        .commit    (commit),
        .op_code   (op_code),
        .src_data  (src_data),
        .call_tgt  (call_tgt),
        .instr_len (instr_len),
        .sp_cur    (sp_out),
        .pc_cur    (pc_out),
        .mem_rdata (mem_rdata),
        .op_q      (op_q),
        .addr_q    (addr_q),
        .wdata_q   (wdata_q),
        .we_q      (we_q),
        .tgt_q     (tgt_q),
        .seq_pc_q  (seq_pc_q),
        .rd_q      (rd_q)
    );

    stk_arch #(.XLEN(XLEN), .SLOT_BYTES(SLOT_BYTES)) u_arch (
        .clk       (clk),
        .rst       (rst),
        .sp_init   (sp_init),
        .pc_init   (pc_init),
        .commit    (commit),
        .op_q      (op_q),
        .addr_q    (addr_q),
        .tgt_q     (tgt_q),
        .seq_pc_q  (seq_pc_q),
        .mem_rdata (mem_rdata),
        .sp_q      (sp_out),
        .pc_q      (pc_out)
    );

    assign mem_we    = mem_req && we_q;
    assign mem_addr  = addr_q;
    assign mem_wdata = wdata_q;
    assign dst_we    = op_done && (op_q == OP_POP);
    assign dst_data  = rd_q;
endmodule

// File: rtl/stack_seq_chk.sv
module stack_seq_chk #(
    parameter int XLEN = 32
) (
    input logic            clk,
    input logic            rst,
    input logic            mem_req,
    input logic            mem_we,
    input logic            mem_ready,
    input logic [XLEN-1:0] mem_addr,
    input logic [XLEN-1:0] mem_wdata,
    input logic [XLEN-1:0] sp_out,
    input logic            op_done,
    input logic            dst_we
);
    p_hold_req_r6: assert property (@(posedge clk) disable iff (rst)
        mem_req && !mem_ready |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

    p_req_drop_r6: assert property (@(posedge clk) disable iff (rst)
        mem_req && mem_ready |=> !mem_req);

    p_write_below_sp_r2: assert property (@(posedge clk) disable iff (rst)
        mem_req && mem_we |-> mem_addr == sp_out - 32'd4);

    p_read_at_sp_r3: assert property (@(posedge clk) disable iff (rst)
        mem_req && !mem_we |-> mem_addr == sp_out);

    p_sp_after_write_r4: assert property (@(posedge clk) disable iff (rst)
        mem_req && mem_ready && mem_we |=> sp_out == $past(mem_addr));

    p_sp_after_read_r5: assert property (@(posedge clk) disable iff (rst)
        mem_req && mem_ready && !mem_we |=> sp_out == $past(mem_addr) + 32'd4);

    p_done_pulse_r7: assert property (@(posedge clk) disable iff (rst)
        op_done |=> !op_done);

    p_done_after_ready_r7: assert property (@(posedge clk) disable iff (rst)
        mem_req && mem_ready |=> op_done);

    p_dst_with_done_r7: assert property (@(posedge clk) disable iff (rst)
        dst_we |-> op_done);
endmodule

bind stack_seq stack_seq_chk #(.XLEN(XLEN)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_ready (mem_ready),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .sp_out    (sp_out),
    .op_done   (op_done),
    .dst_we    (dst_we)
);

// File: tb/test_stack_seq.sv
module test_stack_seq;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] sp_init = 32'h108, pc_init = 32'h0804854e;
    logic        op_valid = 1'b0;
    logic [2:0]  op_code = 3'd0;
    logic [31:0] src_data = '0, call_tgt = '0;
    logic [3:0]  instr_len = 4'd1;
    logic        mem_req, mem_we, mem_ready, dst_we, op_done;
    logic [31:0] mem_addr, mem_wdata, mem_rdata, dst_data, sp_out, pc_out;

    int tests = 0, fails = 0;
    int wait_cfg = 0, wait_cnt = 0, req_cnt = 0;
    logic [31:0] mem [64];
    logic [31:0] last_wa = '0, last_wd = '0;
    logic [31:0] exp_sp, exp_pc;

    always #10 clk = ~clk;

    stack_seq i_stack_seq (
        .clk(clk), .rst(rst), .sp_init(sp_init), .pc_init(pc_init),
        .op_valid(op_valid), .op_code(op_code), .src_data(src_data),
        .call_tgt(call_tgt), .instr_len(instr_len),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ready(mem_ready), .mem_rdata(mem_rdata),
        .dst_we(dst_we), .dst_data(dst_data), .sp_out(sp_out),
        .pc_out(pc_out), .op_done(op_done)
    );

    assign mem_ready = mem_req && (wait_cnt >= wait_cfg);
    assign mem_rdata = mem[mem_addr[7:2]];

    always @(posedge clk) begin
        if (mem_req && !mem_ready) wait_cnt <= wait_cnt + 1;
        else                       wait_cnt <= 0;
        if (mem_req && mem_ready) begin
            req_cnt <= req_cnt + 1;
            if (mem_we) begin
                mem[mem_addr[7:2]] <= mem_wdata;
                last_wa <= mem_addr;
                last_wd <= mem_wdata;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic run_op(input logic [2:0] op, input logic [31:0] src, input logic [31:0] tgt,
                          input logic [3:0] len, output bit got);
        @(negedge clk);
        op_valid = 1'b1; op_code = op; src_data = src; call_tgt = tgt; instr_len = len;
        @(negedge clk);
        op_valid = 1'b0;
        for (int k = 0; k < 40 && !op_done; k++) @(negedge clk);
        got = op_done;
    endtask

    task automatic do_push(input logic [31:0] v, input logic [3:0] len, input string req);
        bit got;
        run_op(3'd1, v, 32'h0, len, got);
        exp_sp = exp_sp - 32'd4; exp_pc = exp_pc + 32'(len);
        chk(got, {req, " push done"}, 32'(got), 32'd1);
        chk(last_wa == exp_sp && last_wd == v, {req, " push write"}, last_wd, v);
        chk(sp_out == exp_sp && pc_out == exp_pc, {req, " push sp/pc"}, sp_out, exp_sp);
    endtask

    task automatic do_pop(input logic [31:0] v, input logic [3:0] len, input string req);
        bit got;
        run_op(3'd2, 32'h0, 32'h0, len, got);
        exp_sp = exp_sp + 32'd4; exp_pc = exp_pc + 32'(len);
        chk(got && dst_we, {req, " pop dst_we"}, 32'(dst_we), 32'd1);
        chk(dst_data == v, {req, " pop data"}, dst_data, v);
        chk(sp_out == exp_sp && pc_out == exp_pc, {req, " pop sp/pc"}, pc_out, exp_pc);
        @(negedge clk);
        chk(!op_done && !dst_we, "R7 single pulse", 32'(op_done), 32'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=0", 1);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        bit got;
        int rc;
        logic [31:0] ret;
        for (int i = 0; i < 64; i++) mem[i] = 32'hDEAD0000 + 32'(i);
        repeat (3) @(negedge clk);
        chk(sp_out == 32'h108, "R1 sp reset", sp_out, 32'h108);
        chk(pc_out == 32'h0804854e, "R1 pc reset", pc_out, 32'h0804854e);
        chk(!mem_req && !op_done && !dst_we, "R1 outputs idle", 32'(mem_req), 32'd0);
        rst = 1'b0;
        exp_sp = 32'h108; exp_pc = 32'h0804854e;

        // R4 example call then R5 return
        run_op(3'd3, 32'h0, 32'h08048b90, 4'd5, got);
        chk(last_wa == 32'h104 && last_wd == 32'h08048553, "R4 return address write", last_wd, 32'h08048553);
        chk(sp_out == 32'h104 && pc_out == 32'h08048b90, "R4 call sp/pc", pc_out, 32'h08048b90);
        run_op(3'd4, 32'h0, 32'h0, 4'd1, got);
        chk(sp_out == 32'h108 && pc_out == 32'h08048553, "R5 return pc", pc_out, 32'h08048553);
        exp_pc = 32'h08048553;

        // R2/R3/R9/R6 sweep over wait states and lengths
        for (int w = 0; w < 4; w++) begin
            wait_cfg = w;
            for (int n = 1; n < 16; n += 5) begin
                do_push(32'hA5000000 + 32'(w * 16 + n), 4'(n), "R2");
                do_push(32'h5A000000 + 32'(w * 16 + n), 4'(n + 1), "R2");
                do_pop(32'h5A000000 + 32'(w * 16 + n), 4'(n), "R9 R3");
                do_pop(32'hA5000000 + 32'(w * 16 + n), 4'(n + 1), "R9 R3");
            end
            // R9 call/return pair with varying length and target
            ret = exp_pc + 32'(w + 2);
            run_op(3'd3, 32'h0, 32'h1000 + 32'(w), 4'(w + 2), got);
            chk(pc_out == 32'h1000 + 32'(w) && sp_out == exp_sp - 32'd4, "R4 call sweep", pc_out, 32'h1000 + 32'(w));
            run_op(3'd4, 32'h0, 32'h0, 4'd1, got);
            chk(pc_out == ret && sp_out == exp_sp, "R9 call/return restore", pc_out, ret);
            exp_pc = ret;
        end

        // R8 op_valid while busy is ignored
        wait_cfg = 3;
        rc = req_cnt;
        @(negedge clk);
        op_valid = 1'b1; op_code = 3'd1; src_data = 32'h11111111; instr_len = 4'd2;
        @(negedge clk);
        op_code = 3'd1; src_data = 32'h22222222;
        @(negedge clk);
        op_valid = 1'b0;
        for (int k = 0; k < 40 && !op_done; k++) @(negedge clk);
        repeat (6) @(negedge clk);
        exp_sp = exp_sp - 32'd4; exp_pc = exp_pc + 32'd2;
        chk(req_cnt == rc + 1, "R8 one request while busy", 32'(req_cnt - rc), 32'd1);
        chk(last_wd == 32'h11111111 && sp_out == exp_sp, "R8 busy ignored", last_wd, 32'h11111111);

        // R8 unused codes
        wait_cfg = 0;
        for (int c = 0; c < 8; c++) begin
            if (c >= 1 && c <= 4) continue;
            rc = req_cnt;
            @(negedge clk);
            op_valid = 1'b1; op_code = 3'(c); instr_len = 4'd3;
            @(negedge clk);
            op_valid = 1'b0;
            repeat (4) @(negedge clk);
            chk(req_cnt == rc && sp_out == exp_sp && pc_out == exp_pc && !op_done,
                "R8 unused code ignored", pc_out, exp_pc);
        end

        // R10 wrap at zero
        rst = 1'b1; sp_init = 32'h0; pc_init = 32'hFFFFFFFE;
        @(negedge clk); @(negedge clk);
        rst = 1'b0;
        exp_sp = 32'h0; exp_pc = 32'hFFFFFFFE;
        do_push(32'hCAFEF00D, 4'd4, "R10");
        chk(last_wa == 32'hFFFFFFFC && pc_out == 32'h2, "R10 wrap", last_wa, 32'hFFFFFFFC);
        do_pop(32'hCAFEF00D, 4'd1, "R10");
        chk(sp_out == 32'h0, "R10 sp back to zero", sp_out, 32'h0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule